// File: doc/BRIEF.md
# Pipelined CORDIC base-2 logarithm

This unit takes a positive unsigned fixed-point mantissa and returns its base-2 logarithm as a signed fixed-point number. It needs no lookup of function values and no general multiplier in its iteration path. First, a linear-mode CORDIC divides (m−1) by (m+1) with shifts and adds. Next, a hyperbolic vectoring-mode CORDIC turns that quotient q into atanh(q), which is half of ln(m). A single constant multiply by 2/ln 2 then gives log2(m).

The unit is fully pipelined. It accepts one sample per clock, each qualified by a valid bit. Each result leaves the unit a fixed number of cycles after its sample, together with its own valid bit and a range flag. Exponent handling is left to the surrounding datapath: the unit sees only the normalised mantissa. Samples outside the range where the hyperbolic iterations converge are flagged rather than computed.

Top module: `cordic_log2`

## Requirements
- R1: For every mantissa raw code from 512 to 32768 inclusive (value = raw/4096, i.e. 0.125 to 8.0), `log2_o` interpreted as signed with 16 fraction bits is within 4.0e-4 of the exact log2, and `range_err_o` is 0.
- R2: For the mantissas 0.4375, 0.9375, 1.3125 and 3.375, the result is within 1.4e-4 of the exact log2.
- R3: A sample presented with `valid_i` high in clock cycle n produces `valid_o` high with its result in cycle n+21.
- R4: Samples presented on consecutive cycles produce results on consecutive cycles, in the same order, with no stall.
- R5: A cycle with `valid_i` low produces a cycle with `valid_o` low exactly 21 cycles later.
- R6: A mantissa raw code below 512 or above 32768, including 0, produces `valid_o` high with `range_err_o` = 1 and `log2_o` = 0.
- R7: Reset clears every pipeline valid bit, so `valid_o` stays low during reset and for 21 cycles after the first possible capture edge unless a valid sample entered.
- R8: `range_err_o` is 0 in every cycle in which `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies `mant_i` in this cycle |
| mant_i | input | 16 | Unsigned mantissa, 4 integer and 12 fraction bits |
| valid_o | output | 1 | Qualifies `log2_o` and `range_err_o` |
| log2_o | output | 20 | Signed log2 result, 16 fraction bits |
| range_err_o | output | 1 | Sample was outside the supported mantissa range |

## Verification
Every result is due exactly 21 cycles after its sample, and every empty input cycle produces an empty output cycle 21 cycles later. The bench drives inputs and samples outputs on falling edges. It keeps one queue entry per driven cycle and compares the entry pushed 21 cycles earlier with the ports on every cycle. This covers valid results, range flags and bubbles. Before the queue fills after reset, every sampled cycle must show `valid_o` low.

// File: rtl/cordic_log2_pkg.sv
package cordic_log2_pkg;

  // atanh(2^-sh) in fixed point with frac fraction bits
  function automatic int atanh_fix(int sh, int frac);
    real t, p, acc;
    t = 1.0;
    for (int j = 0; j < sh; j++) t = t / 2.0;
    p   = t;
    acc = 0.0;
    for (int n = 0; n < 24; n++) begin
      acc = acc + p / real'(2 * n + 1);
      p   = p * t * t;
    end
    for (int j = 0; j < frac; j++) acc = acc * 2.0;
    return $rtoi(acc + 0.5);
  endfunction

  // shift amount of hyperbolic step; shifts 4 and 13 run twice
  function automatic int hyp_shift(int step);
    int sh;
    bit rep;
    sh  = 1;
    rep = 1'b0;
    for (int j = 0; j < step; j++) begin
      if ((sh == 4 || sh == 13) && !rep) rep = 1'b1;
      else begin
        sh  = sh + 1;
        rep = 1'b0;
      end
    end
    return sh;
  endfunction

  function automatic int hyp_steps(int iters);
    return iters + int'(iters >= 4) + int'(iters >= 13);
  endfunction

  // 2/ln(2) = 2*log2(e), kf fraction bits
  function automatic int scale_fix(int kf);
    real k;
    k = 2.0 * 1.4426950408889634;
    for (int j = 0; j < kf; j++) k = k * 2.0;
    return $rtoi(k + 0.5);
  endfunction

endpackage

// File: rtl/cl2_lin_stage.sv
module cl2_lin_stage
  import cordic_log2_pkg::*;
#(
  parameter int DW    = 27,
  parameter int FRAC  = 20,
  parameter int FIRST = 0,
  parameter int COUNT = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  logic                 e_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [DW-1:0] q_i,
  output logic                 v_o,
  output logic                 e_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [DW-1:0] q_o
);

  logic signed [DW-1:0] ys [COUNT+1];
  logic signed [DW-1:0] qs [COUNT+1];

  assign ys[0] = y_i;
  assign qs[0] = q_i;

  for (genvar k = 0; k < COUNT; k++) begin : g_it
    localparam int SH = FIRST + k;
    localparam logic signed [DW-1:0] UNIT = DW'(1) <<< (FRAC - SH);
    logic signed [DW-1:0] xsh;
    assign xsh       = x_i >>> SH;
    assign ys[k+1]   = ys[k][DW-1] ? ys[k] + xsh  : ys[k] - xsh;
    assign qs[k+1]   = ys[k][DW-1] ? qs[k] - UNIT : qs[k] + UNIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= 1'b0;
      e_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
      q_o <= '0;
    end else begin
      v_o <= v_i;
      e_o <= e_i;
      x_o <= x_i;
      y_o <= ys[COUNT];
      q_o <= qs[COUNT];
    end
  end

  // divisor m+1 must stay positive for the sign-driven steps
  assert_divisor_pos_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_o && !e_o) |-> (x_o > 0));

endmodule

// File: rtl/cl2_hyp_stage.sv
module cl2_hyp_stage
  import cordic_log2_pkg::*;
#(
  parameter int DW         = 27,
  parameter int FRAC       = 20,
  parameter int FIRST_STEP = 0,
  parameter int COUNT      = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  logic                 e_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [DW-1:0] z_i,
  output logic                 v_o,
  output logic                 e_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [DW-1:0] z_o
);

  logic signed [DW-1:0] xs [COUNT+1];
  logic signed [DW-1:0] ys [COUNT+1];
  logic signed [DW-1:0] zs [COUNT+1];

  assign xs[0] = x_i;
  assign ys[0] = y_i;
  assign zs[0] = z_i;

  for (genvar k = 0; k < COUNT; k++) begin : g_it
    localparam int SH = hyp_shift(FIRST_STEP + k);
    localparam logic signed [DW-1:0] ANG = DW'(atanh_fix(SH, FRAC));
    logic signed [DW-1:0] xsh, ysh;
    logic                 neg;
    assign xsh     = xs[k] >>> SH;
    assign ysh     = ys[k] >>> SH;
    assign neg     = ys[k][DW-1];
    assign xs[k+1] = neg ? xs[k] + ysh : xs[k] - ysh;
    assign ys[k+1] = neg ? ys[k] + xsh : ys[k] - xsh;
    assign zs[k+1] = neg ? zs[k] - ANG : zs[k] + ANG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= 1'b0;
      e_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      v_o <= v_i;
      e_o <= e_i;
      x_o <= xs[COUNT];
      y_o <= ys[COUNT];
      z_o <= zs[COUNT];
    end
  end

  // inside the convergence region the hyperbolic x never crosses zero
  assert_hyp_x_pos_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_o && !e_o) |-> (x_o > 0));

endmodule

// File: rtl/cl2_scale.sv
module cl2_scale
  import cordic_log2_pkg::*;
#(
  parameter int DW       = 27,
  parameter int FRAC     = 20,
  parameter int KF       = 16,
  parameter int OUT_W    = 20,
  parameter int OUT_FRAC = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    v_i,
  input  logic                    e_i,
  input  logic signed [DW-1:0]    z_i,
  output logic                    v_o,
  output logic                    e_o,
  output logic signed [OUT_W-1:0] res_o
);

  localparam int KW = KF + 3;
  localparam int PW = DW + KW;
  localparam int SH = FRAC + KF - OUT_FRAC;
  localparam logic signed [KW-1:0] K    = KW'(scale_fix(KF));
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH - 1);

  logic                 v_q, e_q;
  logic signed [PW-1:0] prod_q;
  logic signed [PW-1:0] rnd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      e_q    <= 1'b0;
      prod_q <= '0;
    end else begin
      v_q    <= v_i;
      e_q    <= e_i;
      prod_q <= PW'(z_i) * PW'(K);
    end
  end

  assign rnd = prod_q + HALF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= 1'b0;
      e_o   <= 1'b0;
      res_o <= '0;
    end else begin
      v_o   <= v_q;
      e_o   <= v_q & e_q;
      res_o <= e_q ? '0 : rnd[SH+OUT_W-1:SH];
    end
  end

endmodule

// File: rtl/cordic_log2.sv
module cordic_log2
  import cordic_log2_pkg::*;
#(
  parameter int MANT_W    = 16,
  parameter int MANT_FRAC = 12,
  parameter int OUT_W     = 20,
  parameter int OUT_FRAC  = 16,
  parameter int FRAC      = 20,
  parameter int LIN_ITERS = 17,
  parameter int HYP_ITERS = 16,
  parameter int IPS       = 2,
  parameter int KF        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [MANT_W-1:0] mant_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  log2_o,
  output logic              range_err_o
);

  localparam int DW        = FRAC + 7;
  localparam int LIN_STG   = (LIN_ITERS + IPS - 1) / IPS;
  localparam int HYP_STEPS = hyp_steps(HYP_ITERS);
  localparam int HYP_STG   = (HYP_STEPS + IPS - 1) / IPS;
  localparam int LAT       = LIN_STG + HYP_STG + 3;
  localparam int LO_RAW    = 1 << (MANT_FRAC - 3);
  localparam int HI_RAW    = 8 << MANT_FRAC;
  localparam logic signed [DW-1:0] ONE = DW'(1) <<< FRAC;

  // input capture and range gate
  logic                 in_v, in_e;
  logic signed [DW-1:0] in_x, in_y;
  logic signed [DW-1:0] m_fix;
  logic [31:0]          m_ext;

  assign m_ext = 32'(mant_i);
  assign m_fix = DW'(mant_i) <<< (FRAC - MANT_FRAC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_v <= 1'b0;
      in_e <= 1'b0;
      in_x <= '0;
      in_y <= '0;
    end else begin
      in_v <= valid_i;
      in_e <= (m_ext < 32'(LO_RAW)) || (m_ext > 32'(HI_RAW));
      in_x <= m_fix + ONE;
      in_y <= m_fix - ONE;
    end
  end

  // linear CORDIC: q = (m-1)/(m+1)
  logic                 lv [LIN_STG+1];
  logic                 le [LIN_STG+1];
  logic signed [DW-1:0] lx [LIN_STG+1];
  logic signed [DW-1:0] ly [LIN_STG+1];
  logic signed [DW-1:0] lq [LIN_STG+1];

  assign lv[0] = in_v;
  assign le[0] = in_e;
  assign lx[0] = in_x;
  assign ly[0] = in_y;
  assign lq[0] = '0;

  for (genvar s = 0; s < LIN_STG; s++) begin : g_lin
    localparam int CNT = ((s + 1) * IPS <= LIN_ITERS) ? IPS : LIN_ITERS - s * IPS;
    cl2_lin_stage #(.DW(DW), .FRAC(FRAC), .FIRST(s * IPS), .COUNT(CNT)) u_stg (
      .clk_i, .rst_ni,
      .v_i(lv[s]), .e_i(le[s]), .x_i(lx[s]), .y_i(ly[s]), .q_i(lq[s]),
      .v_o(lv[s+1]), .e_o(le[s+1]), .x_o(lx[s+1]), .y_o(ly[s+1]), .q_o(lq[s+1])
    );
  end

  // hyperbolic vectoring: z = atanh(q)
  logic                 hv [HYP_STG+1];
  logic                 he [HYP_STG+1];
  logic signed [DW-1:0] hx [HYP_STG+1];
  logic signed [DW-1:0] hy [HYP_STG+1];
  logic signed [DW-1:0] hz [HYP_STG+1];

  assign hv[0] = lv[LIN_STG];
  assign he[0] = le[LIN_STG];
  assign hx[0] = ONE;
  assign hy[0] = lq[LIN_STG];
  assign hz[0] = '0;

  for (genvar s = 0; s < HYP_STG; s++) begin : g_hyp
    localparam int CNT = ((s + 1) * IPS <= HYP_STEPS) ? IPS : HYP_STEPS - s * IPS;
    cl2_hyp_stage #(.DW(DW), .FRAC(FRAC), .FIRST_STEP(s * IPS), .COUNT(CNT)) u_stg (
      .clk_i, .rst_ni,
      .v_i(hv[s]), .e_i(he[s]), .x_i(hx[s]), .y_i(hy[s]), .z_i(hz[s]),
      .v_o(hv[s+1]), .e_o(he[s+1]), .x_o(hx[s+1]), .y_o(hy[s+1]), .z_o(hz[s+1])
    );
  end

  logic signed [OUT_W-1:0] res;

  cl2_scale #(.DW(DW), .FRAC(FRAC), .KF(KF), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)) u_scale (
    .clk_i, .rst_ni,
    .v_i(hv[HYP_STG]), .e_i(he[HYP_STG]), .z_i(hz[HYP_STG]),
    .v_o(valid_o), .e_o(range_err_o), .res_o(res)
  );

  assign log2_o = res;

  // ---------------- assertions ----------------
  localparam int CW = $clog2(LAT + 1);
  localparam logic signed [DW-1:0]    Q_MAX   = DW'($rtoi(0.8 * real'(1 << FRAC)));
  localparam logic signed [DW-1:0]    Z_MAX   = DW'($rtoi(1.12 * real'(1 << FRAC)));
  localparam logic signed [OUT_W-1:0] OUT_MAX = OUT_W'((3 << OUT_FRAC) + 64);

  logic [CW-1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_rst <= '0;
    else if (since_rst != CW'(LAT)) since_rst <= since_rst + 1'b1;
  end

  assert_quiet_after_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < CW'(LAT)) |-> !valid_o);

  assert_quotient_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv[LIN_STG] && !le[LIN_STG]) |-> (lq[LIN_STG] <= Q_MAX && lq[LIN_STG] >= -Q_MAX));

  assert_angle_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv[HYP_STG] && !he[HYP_STG]) |-> (hz[HYP_STG] <= Z_MAX && hz[HYP_STG] >= -Z_MAX));

  assert_result_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !range_err_o) |-> (res <= OUT_MAX && res >= -OUT_MAX));

endmodule

// File: tb/cordic_log2_bench.sv
module cordic_log2_bench;

  localparam int  CLK_PERIOD = 10;
  localparam int  LAT        = 21;
  localparam real TOL_WIDE   = 4.0e-4;
  localparam real TOL_TIGHT  = 1.4e-4;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic               valid_i;
  logic [15:0]        mant_i;
  logic               valid_o;
  logic signed [19:0] log2_o;
  logic               range_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  bit qv [$];
  int qraw [$];
  bit qt [$];

  cordic_log2 u_cordic_log2 (
    .clk_i, .rst_ni, .valid_i, .mant_i, .valid_o, .log2_o, .range_err_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic check_out();
    bit v, t;
    int raw;
    real act, ex, tol;
    if (qv.size() < LAT) begin
      n_chk++;
      if (valid_o !== 1'b0) begin
        n_fail++;
        $display("FAIL R7 pipeline not empty: valid_o actual=%b expected=0", valid_o);
      end
      return;
    end
    v = qv.pop_front(); raw = qraw.pop_front(); t = qt.pop_front();
    n_chk++;
    if (!v) begin
      if (valid_o !== 1'b0 || range_err_o !== 1'b0) begin
        n_fail++;
        $display("FAIL R5/R8 bubble: valid_o=%b err=%b actual, expected 0 0", valid_o, range_err_o);
      end
    end else if (raw < 512 || raw > 32768) begin
      if (valid_o !== 1'b1 || range_err_o !== 1'b1 || log2_o !== 20'sd0) begin
        n_fail++;
        $display("FAIL R6 raw=%0d actual valid=%b err=%b res=%0d expected 1 1 0",
                 raw, valid_o, range_err_o, log2_o);
      end
    end else begin
      act = real'(log2_o) / 65536.0;
      ex  = $ln(real'(raw) / 4096.0) / $ln(2.0);
      tol = t ? TOL_TIGHT : TOL_WIDE;
      if (valid_o !== 1'b1 || range_err_o !== 1'b0) begin
        n_fail++;
        $display("FAIL R3 raw=%0d actual valid=%b err=%b expected 1 0", raw, valid_o, range_err_o);
      end else if (act - ex > tol || ex - act > tol) begin
        n_fail++;
        $display("FAIL %s raw=%0d actual=%f expected=%f", t ? "R2" : "R1", raw, act, ex);
      end
    end
  endtask

  // one cycle: check outputs due now, then drive the next sample
  task automatic step(bit v, int raw, bit tight);
    @(negedge clk_i);
    check_out();
    valid_i = v;
    mant_i  = 16'(raw);
    qv.push_back(v);
    qraw.push_back(raw);
    qt.push_back(tight);
  endtask

  initial begin
    int lfsr;
    valid_i = 1'b0;
    mant_i  = '0;
    rst_ni  = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b0 || range_err_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R7 reset: valid=%b err=%b actual, expected 0 0", valid_o, range_err_o);
    end
    rst_ni = 1'b1;

    repeat (3) step(1'b0, 0, 1'b0);
    // R2 reference points
    step(1'b1, 3840, 1'b1);
    step(1'b1, 1792, 1'b1);
    step(1'b1, 5376, 1'b1);
    step(1'b1, 13824, 1'b1);
    // R1 range ends and exact powers
    step(1'b1, 512, 1'b0);
    step(1'b1, 32768, 1'b0);
    step(1'b1, 4096, 1'b0);
    step(1'b1, 2048, 1'b0);
    step(1'b1, 8192, 1'b0);
    // R6 out of range
    step(1'b1, 511, 1'b0);
    step(1'b1, 32769, 1'b0);
    step(1'b1, 0, 1'b0);
    step(1'b1, 65535, 1'b0);
    step(1'b1, 100, 1'b0);
    // R5 bubbles interleaved
    for (int i = 0; i < 16; i++) step(i % 3 != 0, 700 + i * 1900, 1'b0);
    // R4 back-to-back sweep
    for (int raw = 512; raw <= 32768; raw += 101) step(1'b1, raw, 1'b0);
    // mixed random traffic
    lfsr = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
      lfsr = lfsr & 32'hFFFF;
      step((lfsr & 3) != 0, (lfsr & 16'h8000) ? lfsr : (lfsr | 16'h0200) & 16'h7FFF, 1'b0);
    end
    repeat (LAT + 4) step(1'b0, 0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule